// File: doc/BRIEF.md
# Dual-Class Prioritized Interrupt Controller

The controller gathers level-sensitive requests from a set of peripheral sources and passes them to a processor core as two classes, fast and normal. Each class has its own request line and its own vector number. Every source has a programmable priority level, a fast-class enable and a normal-class enable. Within each class the pending, enabled request with the highest level sets the vector that is presented to the core.

A control word picks how the vectors are numbered. In autovector mode every normal request presents one fixed number and every fast request presents another. In vectored mode the number is a range base plus the winning level. A second control bit chooses whether fast requests share the normal range or use a range of their own above it. A synchronous register port is used to write and read back the per-source words and the control word. Clearing of peripheral flags stays with software and the peripherals.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset both request outputs are 0, both vectors are 0, and reading back any source word or the control word returns 0. This means level 0, both enables off, and both mode bits off.
- R2: A source word sits at address equal to the source index (0..31). Its layout is bits [4:0] level, bit 5 fast enable and bit 6 normal enable. Bit 7 reads 0. Reads return the written value in `rdData` one clock after `rdEn`.
- R3: A pending source with its fast enable set raises `fastReq`.
- R4: A pending source with only its normal enable set raises `normReq` and leaves `fastReq` low.
- R5: A source with both enables set acts as a fast-class source only and has no effect on the normal class.
- R6: The control word at address 32 has bit 0 for autovector mode and bit 1 for a separate fast range. With bit 0 set, `normVec` is 10 and `fastVec` is 11 whenever the class request is active.
- R7: In vectored mode `normVec` equals 32 plus the level of the winning normal request. A level-0 request therefore gives 32.
- R8: In vectored mode `fastVec` equals 32 plus the winning level when bit 1 is clear, and 64 plus the winning level when bit 1 is set.
- R9: When several enabled sources in one class are pending, the vector follows the highest level among them.
- R10: Requests pass through one synchronizing register. A change on `irqIn` appears at the outputs after the second rising edge. A configuration write appears at the outputs after the edge that follows the write edge.
- R11: A source with both enables clear is ignored. A class with no active request drives its request low and its vector to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqIn | input | 32 | Level requests, one per source |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 6 | Register address (0..31 sources, 32 control) |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Registered read data |
| fastReq | output | 1 | Fast-class request to the core |
| fastVec | output | 7 | Fast-class vector number |
| normReq | output | 1 | Normal-class request to the core |
| normVec | output | 7 | Normal-class vector number |

## Verification
Several rules are checked by assertions on every cycle. A class with no request must show vector 0. An active request must carry a vector that matches the mode bits in force before that edge: the fixed numbers in autovector mode, and the shared or separate range in vectored mode. The outputs must also be quiet right after reset. Other behaviour can only be shown by the bench's scenarios. This covers which source wins among several at different levels, the fast-only handling of a doubly enabled source, the exact level added to the base, the two-edge and one-edge latencies, and the read-back layout.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef struct packed {
    logic srcWr;
    logic ctlWr;
    logic rdStb;
  } irqcStrobe_t;
endpackage

// File: rtl/irqc_ctrl.sv
module irqc_ctrl #(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 6
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output irqc_pkg::irqcStrobe_t stb
);
  localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(NUM_SRC);

  always_comb begin
    stb.srcWr = wrEn && (addr < CTL_ADDR);
    stb.ctlWr = wrEn && (addr == CTL_ADDR);
    stb.rdStb = rdEn;
  end
endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath #(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 5,
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 8,
  parameter int VEC_W   = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqIn,
  input  irqc_pkg::irqcStrobe_t stb,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  output logic               fastReq,
  output logic [VEC_W-1:0]   fastVec,
  output logic               normReq,
  output logic [VEC_W-1:0]   normVec,
  output logic               ctlAe,
  output logic               ctlSep
);
  localparam int IDX_W = $clog2(NUM_SRC);
  localparam int FAST_BIT = PRIO_W;
  localparam int NORM_BIT = PRIO_W + 1;
  localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(NUM_SRC);
  localparam logic [VEC_W-1:0] AUTO_NORM = VEC_W'(10);
  localparam logic [VEC_W-1:0] AUTO_FAST = VEC_W'(11);
  localparam logic [VEC_W-1:0] BASE_LOW  = VEC_W'(32);
  localparam logic [VEC_W-1:0] BASE_HIGH = VEC_W'(64);

  logic [PRIO_W-1:0]  level [NUM_SRC];
  logic [NUM_SRC-1:0] fastEn, normEn, pendSync;
  logic [NUM_SRC-1:0] fastAct, normAct;
  logic [IDX_W-1:0]   idx;
  logic               fAny, nAny;
  logic [PRIO_W-1:0]  fLvl, nLvl;

  assign idx = addr[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fastEn <= '0;
      normEn <= '0;
      ctlAe  <= 1'b0;
      ctlSep <= 1'b0;
      pendSync <= '0;
      for (int i = 0; i < NUM_SRC; i++) level[i] <= '0;
    end else begin
      pendSync <= irqIn;
      if (stb.srcWr) begin
        level[idx]  <= wrData[PRIO_W-1:0];
        fastEn[idx] <= wrData[FAST_BIT];
        normEn[idx] <= wrData[NORM_BIT];
      end
      if (stb.ctlWr) begin
        ctlAe  <= wrData[0];
        ctlSep <= wrData[1];
      end
    end
  end

  // Doubly enabled sources belong to the fast class only.
  assign fastAct = pendSync & fastEn;
  assign normAct = pendSync & normEn & ~fastEn;

  always_comb begin
    fAny = 1'b0; nAny = 1'b0;
    fLvl = '0;   nLvl = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (fastAct[i] && (!fAny || level[i] > fLvl)) begin
        fAny = 1'b1;
        fLvl = level[i];
      end
      if (normAct[i] && (!nAny || level[i] > nLvl)) begin
        nAny = 1'b1;
        nLvl = level[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fastReq <= 1'b0; fastVec <= '0;
      normReq <= 1'b0; normVec <= '0;
      rdData  <= '0;
    end else begin
      fastReq <= fAny;
      normReq <= nAny;
      if (!fAny)      fastVec <= '0;
      else if (ctlAe) fastVec <= AUTO_FAST;
      else            fastVec <= (ctlSep ? BASE_HIGH : BASE_LOW) + VEC_W'(fLvl);
      if (!nAny)      normVec <= '0;
      else if (ctlAe) normVec <= AUTO_NORM;
      else            normVec <= BASE_LOW + VEC_W'(nLvl);
      if (stb.rdStb) begin
        if (addr < CTL_ADDR)
          rdData <= DATA_W'({normEn[idx], fastEn[idx], level[idx]});
        else if (addr == CTL_ADDR)
          rdData <= DATA_W'({ctlSep, ctlAe});
        else
          rdData <= '0;
      end
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 5,
  parameter int DATA_W  = 8,
  parameter int VEC_W   = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [$clog2(NUM_SRC):0] addr,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  output logic               fastReq,
  output logic [VEC_W-1:0]   fastVec,
  output logic               normReq,
  output logic [VEC_W-1:0]   normVec
);
  localparam int ADDR_W = $clog2(NUM_SRC) + 1;

  irqc_pkg::irqcStrobe_t stb;
  logic ctlAe, ctlSep;

  irqc_ctrl #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_ctrl (
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .stb(stb)
  );

  irqc_datapath #(
    .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W),
    .DATA_W(DATA_W), .VEC_W(VEC_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .stb(stb), .addr(addr),
    .wrData(wrData), .rdData(rdData),
    .fastReq(fastReq), .fastVec(fastVec),
    .normReq(normReq), .normVec(normVec),
    .ctlAe(ctlAe), .ctlSep(ctlSep)
  );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int VEC_W = 7
) (
  input logic             clk,
  input logic             rstN,
  input logic             fastReq,
  input logic [VEC_W-1:0] fastVec,
  input logic             normReq,
  input logic [VEC_W-1:0] normVec,
  input logic             aeBit,
  input logic             sepBit
);
  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (!fastReq && !normReq && fastVec == '0 && normVec == '0));

  assert_fast_idle_vec_R11: assert property (@(posedge clk) disable iff (!rstN)
    !fastReq |-> fastVec == '0);

  assert_norm_idle_vec_R11: assert property (@(posedge clk) disable iff (!rstN)
    !normReq |-> normVec == '0);

  assert_auto_vectors_R6: assert property (@(posedge clk) disable iff (!rstN)
    $past(aeBit) |-> ((!fastReq || fastVec == VEC_W'(11)) && (!normReq || normVec == VEC_W'(10))));

  assert_norm_range_R7: assert property (@(posedge clk) disable iff (!rstN)
    (normReq && !$past(aeBit)) |-> (normVec >= VEC_W'(32) && normVec <= VEC_W'(63)));

  assert_fast_range_R8: assert property (@(posedge clk) disable iff (!rstN)
    (fastReq && !$past(aeBit)) |->
      ($past(sepBit) ? (fastVec >= VEC_W'(64) && fastVec <= VEC_W'(95))
                     : (fastVec >= VEC_W'(32) && fastVec <= VEC_W'(63))));
endmodule

bind irq_prio_ctrl irqc_checker #(.VEC_W(VEC_W)) u_chk (
  .clk(clk), .rstN(rstN), .fastReq(fastReq), .fastVec(fastVec),
  .normReq(normReq), .normVec(normVec), .aeBit(ctlAe), .sepBit(ctlSep)
);

// File: tb/test_irq_prio_ctrl.sv
module test_irq_prio_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] irqIn = '0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [5:0]  addr = '0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic        fastReq, normReq;
  logic [6:0]  fastVec, normVec;

  int checks = 0, failures = 0;
  bit finished = 0;

  typedef struct {
    string      tag;
    logic       fr;
    logic [6:0] fv;
    logic       nr;
    logic [6:0] nv;
  } expItem_t;
  expItem_t sbQ[$];

  always #2 clk = ~clk;

  irq_prio_ctrl i_irq_prio_ctrl (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData),
    .fastReq(fastReq), .fastVec(fastVec), .normReq(normReq), .normVec(normVec)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wrEn = 1'b1; addr = 6'(a); wrData = 8'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk);
    rdEn = 1'b1; addr = 6'(a);
    @(negedge clk);
    rdEn = 1'b0;
    v = rdData;
  endtask

  // Driver side of the scoreboard: let the pipeline settle, queue the expectation.
  task automatic expectOut(string tag, logic fr, int fv, logic nr, int nv);
    expItem_t it;
    repeat (3) @(negedge clk);
    it.tag = tag; it.fr = fr; it.fv = 7'(fv); it.nr = nr; it.nv = 7'(nv);
    sbQ.push_back(it);
    wait (sbQ.size() == 0);
  endtask

  // Monitor side: compare the outputs against each queued item.
  initial begin
    forever begin
      expItem_t it;
      wait (sbQ.size() > 0);
      @(posedge clk);
      #1;
      it = sbQ[0];
      chk({it.tag, " fastReq"}, int'(fastReq), int'(it.fr));
      chk({it.tag, " fastVec"}, int'(fastVec), int'(it.fv));
      chk({it.tag, " normReq"}, int'(normReq), int'(it.nr));
      chk({it.tag, " normVec"}, int'(normVec), int'(it.nv));
      void'(sbQ.pop_front());
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: outputs quiet and registers cleared after reset
    chk("R1 fastReq", int'(fastReq), 0);
    chk("R1 normReq", int'(normReq), 0);
    rd(3, v);  chk("R1 src3 word", v, 0);
    rd(32, v); chk("R1 ctl word", v, 0);

    // R11: all requests pending, nothing enabled
    irqIn = '1;
    expectOut("R11 none enabled", 0, 0, 0, 0);
    irqIn = '0;

    // R4 R7: normal source 3 at level 7
    wr(3, 8'h47);
    irqIn[3] = 1'b1;
    expectOut("R4 R7 normal lvl7", 0, 0, 1, 39);

    // R3 R8 shared range: fast source 5 at level 4
    wr(5, 8'h24);
    irqIn[5] = 1'b1;
    expectOut("R3 R8 fast shared", 1, 36, 1, 39);

    // R8 separate range
    wr(32, 8'h02);
    expectOut("R8 fast separate", 1, 68, 1, 39);

    // R6 autovector mode
    wr(32, 8'h03);
    expectOut("R6 autovector", 1, 11, 1, 10);
    wr(32, 8'h00);

    // R9 highest level wins within the normal class
    wr(9, 8'h54);
    irqIn[9] = 1'b1;
    expectOut("R9 normal lvl20 wins", 1, 36, 1, 52);
    irqIn[9] = 1'b0;
    expectOut("R9 back to lvl7", 1, 36, 1, 39);

    // R5 doubly enabled source goes to fast class only
    wr(12, 8'h7F);
    irqIn[12] = 1'b1;
    expectOut("R5 both enables", 1, 63, 1, 39);

    // R2 read-back layout
    rd(12, v); chk("R2 src12 word", v, 8'h7F);
    rd(5, v);  chk("R2 src5 word", v, 8'h24);
    wr(32, 8'h02);
    rd(32, v); chk("R2 ctl word", v, 2);
    wr(32, 8'h00);
    expectOut("R2 restore", 1, 63, 1, 39);

    // R10 request latency: two edges
    @(negedge clk);
    irqIn[3] = 1'b0;
    @(negedge clk);
    chk("R10 after one edge normReq", int'(normReq), 1);
    @(negedge clk);
    chk("R10 after two edges normReq", int'(normReq), 0);
    chk("R10 after two edges normVec", int'(normVec), 0);

    // R10 configuration latency: one edge after the write edge
    wr(32, 8'h01);
    chk("R10 cfg same edge fastVec", int'(fastVec), 63);
    @(negedge clk);
    chk("R10 cfg next edge fastVec", int'(fastVec), 11);
    wr(32, 8'h00);

    // R7 boundary: level 0 normal source gives 32
    wr(20, 8'h40);
    irqIn[20] = 1'b1;
    expectOut("R7 level0", 1, 63, 1, 32);

    // R11: disabling sources removes them
    wr(20, 8'h00);
    wr(12, 8'h00);
    wr(5, 8'h00);
    expectOut("R11 disabled idle", 0, 0, 0, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule